// File: doc/BRIEF.md
# Phase-Shifted Gate Pattern Generator for a Three-Phase Isolated Inverter

This block produces every gate drive signal for a single-stage, three-phase DC-to-AC converter built around high-frequency transformers. On the primary side there are four half-bridge legs. Leg 0 is the reference leg, which runs a fixed 50% square wave whose period is one switching period (the transformer flux balance period). Legs 1 to 3 serve phases a, b and c. Each one runs the same 50% square wave, delayed from the reference by its own modulation fraction times half a switching period. The width of the quasi-square voltage across each transformer primary then follows that phase's modulation magnitude.

On the secondary side there are three unfolding legs. Each one selects its upper switch while the phase sign is positive and its lower switch otherwise, so these legs only change at line frequency. Every leg, primary and secondary, has a programmable dead time between its two gates. Modulation magnitudes and signs are supplied by an upstream sine-reference stage. They are sampled once per switching period, at the period boundary. The enable input gates the whole pattern on and off at period granularity.

All inputs are plain level-sensitive control pins. There is no stream interface and no back-pressure: the block samples whatever values are present at each period boundary.

Top module: `hfl_gate_gen`

## Requirements
- R1: The reference top gate (pri_hi[0]) is periodic with a period of 2·HALF_TICKS clock cycles.
- R2: In every primary leg, the top and bottom gates are complementary and are never high together. Each gate stays high for HALF_TICKS−(dead_cyc+1) cycles per period.
- R3: In leg i (i = 1, 2, 3 for phases a, b, c), the rising edge of the top gate follows the rising edge of the reference top gate by floor(m·HALF_TICKS / 2^MOD_W) cycles. Here m is the unsigned MOD_W-bit fraction on mod_a, mod_b or mod_c.
- R4: A modulation value takes effect only from the next period boundary (the clock where the free-running counter wraps to 0). A change made partway through a period leaves that period's delay unchanged.
- R5: Secondary leg j (bit j of sign_abc: 0 = a, 1 = b, 2 = c) drives sec_hi[j] when the sign bit is 1 and sec_lo[j] when it is 0. The sign is sampled only at the period boundary, and sec_hi[j] and sec_lo[j] are never high together.
- R6: After a gate of any leg falls, the other gate of that leg rises exactly dead_cyc+1 cycles later when it is requested at once. It never rises earlier than that.
- R7: Once en has been low at a clock edge, all fourteen gates are low from the second following edge onward, for as long as en stays low.
- R8: After en rises again, the first rise of the reference top gate falls on the same period grid as before the pause.
- R9: While rst_n is low, all gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of the timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request; gates are released at the next period boundary |
| dead_cyc | input | DT_W | Dead time in clock cycles (off-window is dead_cyc+1) |
| mod_a | input | MOD_W | Phase a modulation magnitude, unsigned fraction |
| mod_b | input | MOD_W | Phase b modulation magnitude, unsigned fraction |
| mod_c | input | MOD_W | Phase c modulation magnitude, unsigned fraction |
| sign_abc | input | 3 | Phase signs, bit 0 = a; 1 = positive |
| pri_hi | output | 4 | Primary top gates, bit 0 = reference leg, bits 1..3 = a, b, c |
| pri_lo | output | 4 | Primary bottom gates, same bit order |
| sec_hi | output | 3 | Secondary unfolding top gates, bit 0 = a |
| sec_lo | output | 3 | Secondary unfolding bottom gates, bit 0 = a |

## Verification
The bench builds the block with HALF_TICKS = 40, MOD_W = 8 and DT_W = 4, so a full switching period lasts 80 cycles. At that size, many complete periods, several mid-period input changes and an enable pause all fit in a short run. With a 256-step fraction on a 40-cycle half period, the scaling floor is exercised with non-integer products (200 → 31, 1 → 0, 255 → 39) as well as exact ones. Dead times of 3 and 6 cycles show that the gate widths shrink with dead time while the phase delays between legs do not change.

// File: rtl/hfl_pkg.sv
package hfl_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;

  localparam int unsigned NUM_PRI_LEGS = 4;
  localparam int unsigned NUM_PHASES   = 3;

endpackage

// File: rtl/hfl_timebase.sv
module hfl_timebase #(
  parameter int unsigned HALF_TICKS = 2500,
  parameter int unsigned CW         = $clog2(2 * HALF_TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          at_last
);
  localparam int unsigned PERIOD = 2 * HALF_TICKS;

  assign at_last = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (at_last) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hfl_phase_shift.sv
module hfl_phase_shift #(
  parameter int unsigned HALF_TICKS = 2500,
  parameter int unsigned MOD_W      = 12,
  parameter int unsigned CW         = $clog2(2 * HALF_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MOD_W-1:0] mod,
  input  logic [CW-1:0]    cnt,
  output logic             want_hi
);
  localparam int unsigned PERIOD = 2 * HALF_TICKS;
  localparam int unsigned PW     = MOD_W + CW;

  logic [PW-1:0] prod;
  logic [CW-1:0] delay_q;
  logic [CW:0]   pos;

  // fraction times half period, floor
  assign prod = {{CW{1'b0}}, mod} * PW'(HALF_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    delay_q <= '0;
    else if (load) delay_q <= prod[MOD_W +: CW];
  end

  // position of this leg inside its own delayed period
  always_comb begin
    if (cnt >= delay_q) pos = {1'b0, cnt} - {1'b0, delay_q};
    else                pos = {1'b0, cnt} + (CW+1)'(PERIOD) - {1'b0, delay_q};
  end

  assign want_hi = (pos < (CW+1)'(HALF_TICKS));
endmodule

// File: rtl/hfl_deadband.sv
module hfl_deadband
  import hfl_pkg::*;
#(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            want_hi,
  input  logic [DT_W-1:0] dead_cyc,
  output gate_pair_t      gate
);
  logic [DT_W-1:0] idle_q;
  logic            hi_q, lo_q;
  logic            gap_ok;

  assign gap_ok = !hi_q && !lo_q && (idle_q >= dead_cyc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      idle_q <= '0;
    end else if (clr) begin
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      idle_q <= '0;
    end else begin
      hi_q <= want_hi  && (hi_q || gap_ok);
      lo_q <= !want_hi && (lo_q || gap_ok);
      if (hi_q || lo_q)     idle_q <= '0;
      else if (~&idle_q)    idle_q <= idle_q + 1'b1;
    end
  end

  assign gate.hi = hi_q;
  assign gate.lo = lo_q;
endmodule

// File: rtl/hfl_gate_gen.sv
module hfl_gate_gen
  import hfl_pkg::*;
#(
  parameter int unsigned HALF_TICKS = 2500,
  parameter int unsigned MOD_W      = 12,
  parameter int unsigned DT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DT_W-1:0]  dead_cyc,
  input  logic [MOD_W-1:0] mod_a,
  input  logic [MOD_W-1:0] mod_b,
  input  logic [MOD_W-1:0] mod_c,
  input  logic [2:0]       sign_abc,
  output logic [3:0]       pri_hi,
  output logic [3:0]       pri_lo,
  output logic [2:0]       sec_hi,
  output logic [2:0]       sec_lo
);
  localparam int unsigned CW = $clog2(2 * HALF_TICKS);

  logic [CW-1:0]    cnt;
  logic             at_last;
  logic             run_q, run_d;
  logic             clr;
  logic [MOD_W-1:0] leg_mod [NUM_PRI_LEGS];
  logic [NUM_PRI_LEGS-1:0] leg_want;
  logic [NUM_PHASES-1:0]   sgn_q;

  hfl_timebase #(.HALF_TICKS(HALF_TICKS), .CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .at_last(at_last)
  );

  // run starts only on a period boundary, stops at once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      run_d <= 1'b0;
      sgn_q <= '0;
    end else begin
      if (!en)          run_q <= 1'b0;
      else if (at_last) run_q <= 1'b1;
      run_d <= run_q;
      if (at_last) sgn_q <= sign_abc;
    end
  end

  // one extra held cycle keeps the first release on the normal dead-time grid
  assign clr = !(run_q && run_d);

  assign leg_mod[0] = '0;
  assign leg_mod[1] = mod_a;
  assign leg_mod[2] = mod_b;
  assign leg_mod[3] = mod_c;

  for (genvar i = 0; i < NUM_PRI_LEGS; i++) begin : g_pri
    gate_pair_t pair;
    hfl_phase_shift #(.HALF_TICKS(HALF_TICKS), .MOD_W(MOD_W), .CW(CW)) u_ps (
      .clk(clk), .rst_n(rst_n), .load(at_last), .mod(leg_mod[i]),
      .cnt(cnt), .want_hi(leg_want[i])
    );
    hfl_deadband #(.DT_W(DT_W)) u_db (
      .clk(clk), .rst_n(rst_n), .clr(clr), .want_hi(leg_want[i]),
      .dead_cyc(dead_cyc), .gate(pair)
    );
    assign pri_hi[i] = pair.hi;
    assign pri_lo[i] = pair.lo;
  end

  for (genvar j = 0; j < NUM_PHASES; j++) begin : g_sec
    gate_pair_t pair;
    hfl_deadband #(.DT_W(DT_W)) u_db (
      .clk(clk), .rst_n(rst_n), .clr(clr), .want_hi(sgn_q[j]),
      .dead_cyc(dead_cyc), .gate(pair)
    );
    assign sec_hi[j] = pair.hi;
    assign sec_lo[j] = pair.lo;
  end
endmodule

// File: rtl/hfl_gate_chk.sv
module hfl_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [3:0] pri_hi,
  input logic [3:0] pri_lo,
  input logic [2:0] sec_hi,
  input logic [2:0] sec_lo
);
  // R2
  pri_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_hi & pri_lo) == 4'b0);

  // R5
  sec_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_hi & sec_lo) == 3'b0);

  // R6
  pri_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((pri_hi & ~$past(pri_hi)) & $past(pri_lo)) |
     ((pri_lo & ~$past(pri_lo)) & $past(pri_hi))) == 4'b0);

  // R6
  sec_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((sec_hi & ~$past(sec_hi)) & $past(sec_lo)) |
     ((sec_lo & ~$past(sec_lo)) & $past(sec_hi))) == 3'b0);

  // R7
  off_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en, 2) |-> (pri_hi == 4'b0 && pri_lo == 4'b0 &&
                       sec_hi == 3'b0 && sec_lo == 3'b0));
endmodule

bind hfl_gate_gen hfl_gate_chk u_gate_chk (
  .clk(clk), .rst_n(rst_n), .en(en),
  .pri_hi(pri_hi), .pri_lo(pri_lo), .sec_hi(sec_hi), .sec_lo(sec_lo)
);

// File: tb/test_hfl_gate_gen.sv
module test_hfl_gate_gen;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 40;
  localparam int PER  = 2 * HALF;

  typedef struct {
    string tag;
    int    val;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] dead_cyc = 4'd3;
  logic [7:0] mod_a = '0, mod_b = '0, mod_c = '0;
  logic [2:0] sign_abc = '0;
  logic [3:0] pri_hi, pri_lo;
  logic [2:0] sec_hi, sec_lo;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, overlap = 0, last_ref_rise = 0;
  logic [7:0] prev_v = '0, rise_v = '0, fall_v = '0;
  exp_t exp_q[$];
  event req_ev;

  hfl_gate_gen #(.HALF_TICKS(HALF), .MOD_W(8), .DT_W(4)) i_hfl_gate_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .dead_cyc(dead_cyc),
    .mod_a(mod_a), .mod_b(mod_b), .mod_c(mod_c), .sign_abc(sign_abc),
    .pri_hi(pri_hi), .pri_lo(pri_lo), .sec_hi(sec_hi), .sec_lo(sec_lo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // sampler: edge flags per primary gate, bits 0..3 top, 4..7 bottom
  always @(negedge clk) begin
    logic [7:0] v;
    v = {pri_lo, pri_hi};
    cyc = cyc + 1;
    rise_v = v & ~prev_v;
    fall_v = ~v & prev_v;
    prev_v = v;
    if (rst_n && (((pri_hi & pri_lo) != 0) || ((sec_hi & sec_lo) != 0))) overlap++;
    if (rise_v[0]) last_ref_rise = cyc;
  end

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wait_edge(input int sel, input bit rising);
    do begin
      @(negedge clk); #1;
    end while (!(rising ? rise_v[sel] : fall_v[sel]));
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // driver side of the scoreboard
  task automatic expect_delays(input int da, input int db, input int dc);
    exp_q.push_back('{"R3 phase a delay", da});
    exp_q.push_back('{"R3 phase b delay", db});
    exp_q.push_back('{"R3 phase c delay", dc});
    -> req_ev;
    wait (exp_q.size() == 0);
  endtask

  // monitor side: measure one period, compare against queued items
  initial begin
    forever begin
      int got[3];
      exp_t it;
      @(req_ev);
      got = '{-1, -1, -1};
      wait_edge(0, 1'b1);
      for (int k = 0; k < PER; k++) begin
        if (k > 0) begin @(negedge clk); #1; end
        for (int i = 1; i < 4; i++)
          if (rise_v[i] && got[i-1] < 0) got[i-1] = k;
      end
      for (int i = 0; i < 3; i++) begin
        it = exp_q.pop_front();
        chk(it.tag, got[i], it.val);
      end
    end
  end

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int c1, w;
    skip(5);
    // R9
    chk("R9 gates in reset", {pri_hi, pri_lo, sec_hi, sec_lo}, 0);
    rst_n = 1'b1;
    mod_a = 8'd128; mod_b = 8'd64; mod_c = 8'd255;
    sign_abc = 3'b101;
    en = 1'b1;
    skip(3 * PER);

    // R1
    wait_edge(0, 1'b1); c1 = cyc;
    wait_edge(0, 1'b1);
    chk("R1 reference period", cyc - c1, PER);

    // R2 widths with dead time 3
    wait_edge(0, 1'b1); c1 = cyc; wait_edge(0, 1'b0);
    chk("R2 ref top width", cyc - c1, HALF - 4);
    wait_edge(4, 1'b1); c1 = cyc; wait_edge(4, 1'b0);
    chk("R2 ref bottom width", cyc - c1, HALF - 4);
    wait_edge(1, 1'b1); c1 = cyc; wait_edge(1, 1'b0);
    chk("R2 phase a top width", cyc - c1, HALF - 4);

    // R3 several patterns
    expect_delays(20, 10, 39);
    mod_a = 8'd0; mod_b = 8'd200; mod_c = 8'd1;
    skip(2 * PER);
    expect_delays(0, 31, 0);

    // R6 dead gap at 3, then 6
    wait_edge(4, 1'b0); c1 = cyc; wait_edge(0, 1'b1);
    chk("R6 gap dead 3", cyc - c1, 4);
    dead_cyc = 4'd6;
    skip(2 * PER);
    wait_edge(4, 1'b0); c1 = cyc; wait_edge(0, 1'b1);
    chk("R6 gap dead 6", cyc - c1, 7);
    wait_edge(0, 1'b1); c1 = cyc; wait_edge(0, 1'b0);
    chk("R2 ref top width dead 6", cyc - c1, HALF - 7);
    expect_delays(0, 31, 0);
    dead_cyc = 4'd3;
    skip(2 * PER);

    // R5 unfolding follows sign, changed only at the boundary
    chk("R5 sec_hi sign 101", sec_hi, 3'b101);
    chk("R5 sec_lo sign 101", sec_lo, 3'b010);
    wait_edge(0, 1'b1);
    sign_abc = 3'b010;
    skip(10);
    chk("R5 sec_hi held mid-period", sec_hi, 3'b101);
    skip(2 * PER);
    chk("R5 sec_hi sign 010", sec_hi, 3'b010);
    chk("R5 sec_lo sign 010", sec_lo, 3'b101);

    // R4 mid-period change keeps this period's delay
    mod_a = 8'd200;
    skip(2 * PER);
    wait_edge(0, 1'b1);
    w = -1;
    for (int k = 1; k < PER; k++) begin
      @(negedge clk); #1;
      if (k == 5) mod_a = 8'd64;
      if (rise_v[1] && w < 0) w = k;
    end
    chk("R4 delay held after mid-period write", w, 31);
    expect_delays(10, 31, 0);

    // R7 disable
    skip(7);
    en = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk); #1;
    chk("R7 gates off after disable", {pri_hi, pri_lo, sec_hi, sec_lo}, 0);
    w = 0;
    for (int k = 0; k < PER; k++) begin
      @(negedge clk); #1;
      if ({pri_hi, pri_lo, sec_hi, sec_lo} != 0) w++;
    end
    chk("R7 gates stay off", w, 0);

    // R8 restart aligned to the period grid
    c1 = last_ref_rise;
    skip(37);
    en = 1'b1;
    wait_edge(0, 1'b1);
    chk("R8 restart phase", (cyc - c1) % PER, 0);
    expect_delays(10, 31, 0);

    // R2 / R5 mutual exclusion over the whole run
    chk("R2 R5 overlap count", overlap, 0);

    summary();
    $finish;
  end
endmodule